// File: doc/BRIEF.md
# Command Queue Thread Controller

A single hardware execution thread for a command-queue engine. Software programs it through a small register window: a start position (the program counter), a stop position (the end address), an interrupt enable mask and a priority. It then sets the run bit. The thread fetches 8-byte instructions over a read port that allows one request in flight. It executes them in order until the program counter equals the end address, then raises a done flag and clears its own run bit. Command buffers in different places in memory are chained with an absolute jump instruction.

Software can pause the thread at an instruction boundary and read back when the pause has really taken effect. It can restart the thread from scratch with a warm reset that clears itself, and it can redirect the thread by writing the program counter. Any such write throws away an instruction that was already fetched, so the thread always fetches again. A wait instruction parks the thread until an external event pulse arrives, and a status bit shows this. An unknown opcode raises an error flag and leaves the thread paused on the offending instruction.

The program counter and the end address are held as byte addresses shifted right by the parameter `SHIFT` (0 or 3). One instruction therefore advances the counter by `8 >> SHIFT`, and the byte address sent to memory is the counter shifted left by `SHIFT`.

Top module: `cmd_thread_ctrl`

## Requirements
- R1: After the reset input, every register reads zero, `irq` is 0 and no fetch is requested.
- R2: Writing 1 to bit 0 at offset 0x00 starts a warm reset. The bit reads 1 for at least `RST_CYCLES` cycles and until no fetch is in flight, then clears itself. While it reads 1, writes to other registers are ignored. Afterwards the run bit (0x04), pause request (0x08), interrupt status (0x10), interrupt enables (0x14), program counter (0x20), end address (0x24) and priority (0x40) all read zero, and no fetch is issued.
- R3: While bit 0 at 0x04 is 1, the thread fetches the instruction at byte address PC << SHIFT, with at most one fetch in flight. An instruction whose upper byte is 0x80 is a plain command and advances PC by 8 >> SHIFT.
- R4: When PC equals the end address and no instruction is held, the thread sets interrupt status bit 0 (done) and clears bit 0 at 0x04.
- R5: An instruction whose upper 32-bit word is 0x10000001 is a jump: PC takes the lower 32-bit word, which holds the byte target shifted right by SHIFT.
- R6: An instruction whose upper byte is 0x20 waits. PC stays put until `evt_go` is 1 at a clock edge, then advances by 8 >> SHIFT. While the wait is pending, bit 31 at 0x30 reads 1.
- R7: Any other instruction sets interrupt status bit 1 (error) and sets the pause request. PC keeps the address of that instruction.
- R8: Writing 1 at 0x08 requests a pause and writing 0 resumes. No new fetch starts while the request is 1. Bit 1 at 0x0C reads 1 once the request is 1 and no fetch is in flight.
- R9: Any write to 0x20, including writing back its current value, discards the held instruction and any fetch in flight. The next fetch uses the written PC.
- R10: Interrupt status bits 0, 1 and 4 are live. Writing 0 to a bit clears it and writing 1 leaves it unchanged. `irq` is the OR of the status bits ANDed with the enables at 0x14.
- R11: The priority register at 0x40 stores and returns its low `PRIO_W` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register offset for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| mem_req | output | 1 | One-cycle fetch request |
| mem_addr | output | PC_W+SHIFT | Byte address of the fetch |
| mem_valid | input | 1 | Fetch data returned this cycle |
| mem_rdata | input | 64 | Returned instruction |
| evt_go | input | 1 | Event pulse that releases a wait instruction |
| irq | output | 1 | Thread interrupt |

## Verification
The assertions assume that `mem_valid` arrives only for a request that is still in flight, with exactly one response per request. They also assume that `evt_go` and the register strobes are clean single-cycle inputs. The bench memory model answers each request once, a fixed two cycles later. All register traffic goes through one write task and one read task that change inputs only at the falling edge. The fetch scoreboard predicts the address sequence from the program the bench has loaded. It runs in strict mode, where any fetch it did not predict counts as a failure, except during the endless loop used for the pause and rewrite cases.

// File: rtl/cth_pkg.sv
package cth_pkg;
  typedef enum logic [1:0] {K_CMD, K_JMP, K_WAIT, K_BAD} op_kind_e;

  localparam logic [31:0] JUMP_ABS_WORD = 32'h1000_0001;
  localparam logic [7:0]  CMD_OPC       = 8'h80;
  localparam logic [7:0]  WAIT_OPC      = 8'h20;

  localparam int          IRQ_W     = 5;
  localparam logic [4:0]  IRQ_DONE  = 5'b00001;
  localparam logic [4:0]  IRQ_BADOP = 5'b00010;
  localparam logic [4:0]  IRQ_LIVE  = 5'b10011;

  localparam logic [7:0] OFF_WRST = 8'h00;
  localparam logic [7:0] OFF_RUN  = 8'h04;
  localparam logic [7:0] OFF_HOLD = 8'h08;
  localparam logic [7:0] OFF_STAT = 8'h0C;
  localparam logic [7:0] OFF_ISTS = 8'h10;
  localparam logic [7:0] OFF_IEN  = 8'h14;
  localparam logic [7:0] OFF_PC   = 8'h20;
  localparam logic [7:0] OFF_END  = 8'h24;
  localparam logic [7:0] OFF_WAIT = 8'h30;
  localparam logic [7:0] OFF_PRIO = 8'h40;

  function automatic op_kind_e classify(logic [63:0] w);
    if (w[63:32] == JUMP_ABS_WORD)  return K_JMP;
    if (w[63:56] == CMD_OPC)        return K_CMD;
    if (w[63:56] == WAIT_OPC)       return K_WAIT;
    return K_BAD;
  endfunction

  function automatic logic [63:0] advance(logic [63:0] pc, int shift);
    return pc + (64'd8 >> shift);
  endfunction

  function automatic logic [63:0] to_bytes(logic [63:0] pc, int shift);
    return pc << shift;
  endfunction
endpackage

// File: rtl/cth_fetch.sv
module cth_fetch (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        issue,
  input  logic        flush,
  input  logic        consume,
  input  logic        mem_valid,
  input  logic [63:0] mem_rdata,
  output logic        pend,
  output logic        buf_valid,
  output logic [63:0] buf_word
);
  logic drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      drop      <= 1'b0;
      buf_valid <= 1'b0;
      buf_word  <= '0;
    end else begin
      if (issue) pend <= 1'b1;
      if (mem_valid && pend) begin
        pend <= 1'b0;
        drop <= 1'b0;
        if (!drop && !flush) begin
          buf_valid <= 1'b1;
          buf_word  <= mem_rdata;
        end
      end else if (flush && pend) begin
        drop <= 1'b1;
      end
      if (consume || flush) buf_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cth_regfile.sv
module cth_regfile
  import cth_pkg::*;
#(
  parameter int PC_W       = 32,
  parameter int PRIO_W     = 3,
  parameter int RST_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rst_go,
  input  logic              wr_run,
  input  logic              wr_hold,
  input  logic              wr_ists,
  input  logic              wr_ien,
  input  logic              wr_end,
  input  logic              wr_prio,
  input  logic [31:0]       wdata,
  input  logic              fetch_pend,
  input  logic              hw_done,
  input  logic              hw_err,
  output logic              busy,
  output logic              en,
  output logic              hold_req,
  output logic [IRQ_W-1:0]  ists,
  output logic [IRQ_W-1:0]  ien,
  output logic [PC_W-1:0]   end_addr,
  output logic [PRIO_W-1:0] prio,
  output logic              irq
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; cnt <= '0; en <= 1'b0; hold_req <= 1'b0;
      ists <= '0; ien <= '0; end_addr <= '0; prio <= '0;
    end else if (busy || rst_go) begin
      en <= 1'b0; hold_req <= 1'b0; ists <= '0; ien <= '0;
      end_addr <= '0; prio <= '0;
      if (rst_go) begin
        busy <= 1'b1;
        cnt  <= CW'(RST_CYCLES);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else if (!fetch_pend) begin
        busy <= 1'b0;
      end
    end else begin
      if (hw_done)      en <= 1'b0;
      else if (wr_run)  en <= wdata[0];
      if (hw_err)       hold_req <= 1'b1;
      else if (wr_hold) hold_req <= wdata[0];
      ists <= ((wr_ists ? (ists & wdata[IRQ_W-1:0]) : ists)
               | (hw_done ? IRQ_DONE : '0)
               | (hw_err ? IRQ_BADOP : '0)) & IRQ_LIVE;
      if (wr_ien)  ien <= wdata[IRQ_W-1:0] & IRQ_LIVE;
      if (wr_end)  end_addr <= PC_W'(wdata);
      if (wr_prio) prio <= wdata[PRIO_W-1:0];
    end
  end

  assign irq = |(ists & ien);
endmodule

// File: rtl/cmd_thread_ctrl.sv
module cmd_thread_ctrl
  import cth_pkg::*;
#(
  parameter int SHIFT      = 0,
  parameter int PC_W       = 32,
  parameter int PRIO_W     = 3,
  parameter int RST_CYCLES = 4,
  localparam int BAW       = PC_W + SHIFT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [7:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  output logic            mem_req,
  output logic [BAW-1:0]  mem_addr,
  input  logic            mem_valid,
  input  logic [63:0]     mem_rdata,
  input  logic            evt_go,
  output logic            irq
);
  logic              busy, en, hold_req, pend, buf_valid;
  logic [IRQ_W-1:0]  ists, ien;
  logic [PC_W-1:0]   pc, end_addr;
  logic [PRIO_W-1:0] prio;
  logic [63:0]       buf_word;
  op_kind_e          kind;

  // named internal events, shared by the logic and the assertions
  logic wr_ok, rst_go, wr_pc, run, issue, finish, exec, consume, hw_err, waiting;

  assign wr_ok   = reg_we && !busy;
  assign rst_go  = wr_ok && reg_addr == OFF_WRST && reg_wdata[0];
  assign wr_pc   = wr_ok && reg_addr == OFF_PC;
  assign kind    = classify(buf_word);
  assign run     = en && !hold_req && !busy && !rst_go;
  assign issue   = run && !pend && !buf_valid && pc != end_addr && !wr_pc;
  assign finish  = run && !pend && !buf_valid && pc == end_addr && !wr_pc;
  assign exec    = run && buf_valid && !wr_pc;
  assign consume = exec && (kind != K_WAIT || evt_go);
  assign hw_err  = exec && kind == K_BAD;
  assign waiting = en && buf_valid && kind == K_WAIT;

  assign mem_req  = issue;
  assign mem_addr = BAW'(to_bytes(64'(pc), SHIFT));

  cth_regfile #(.PC_W(PC_W), .PRIO_W(PRIO_W), .RST_CYCLES(RST_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .rst_go(rst_go),
    .wr_run (wr_ok && reg_addr == OFF_RUN),
    .wr_hold(wr_ok && reg_addr == OFF_HOLD),
    .wr_ists(wr_ok && reg_addr == OFF_ISTS),
    .wr_ien (wr_ok && reg_addr == OFF_IEN),
    .wr_end (wr_ok && reg_addr == OFF_END),
    .wr_prio(wr_ok && reg_addr == OFF_PRIO),
    .wdata(reg_wdata), .fetch_pend(pend), .hw_done(finish), .hw_err(hw_err),
    .busy(busy), .en(en), .hold_req(hold_req), .ists(ists), .ien(ien),
    .end_addr(end_addr), .prio(prio), .irq(irq)
  );

  cth_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .issue(issue), .flush(wr_pc || rst_go),
    .consume(consume), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .pend(pend), .buf_valid(buf_valid), .buf_word(buf_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pc <= '0;
    else if (busy || rst_go)   pc <= '0;
    else if (wr_pc)            pc <= PC_W'(reg_wdata);
    else if (consume) begin
      case (kind)
        K_JMP:   pc <= PC_W'(buf_word[31:0]);
        K_CMD,
        K_WAIT:  pc <= PC_W'(advance(64'(pc), SHIFT));
        default: pc <= pc;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFF_WRST: reg_rdata[0]            = busy;
      OFF_RUN:  reg_rdata[0]            = en;
      OFF_HOLD: reg_rdata[0]            = hold_req;
      OFF_STAT: reg_rdata[1]            = hold_req && !pend;
      OFF_ISTS: reg_rdata[IRQ_W-1:0]    = ists;
      OFF_IEN:  reg_rdata[IRQ_W-1:0]    = ien;
      OFF_PC:   reg_rdata               = 32'(pc);
      OFF_END:  reg_rdata               = 32'(end_addr);
      OFF_WAIT: reg_rdata[31]           = waiting;
      OFF_PRIO: reg_rdata[PRIO_W-1:0]   = prio;
      default:  reg_rdata               = '0;
    endcase
  end

  // R3: an issued fetch is tracked as in flight by the fetch unit
  assert_fetch_tracked_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> pend);
  // R9: a program-counter write leaves nothing buffered
  assert_pcwr_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_pc |=> !buf_valid);
  // R4: reaching the end raises done and stops the thread
  assert_done_stop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (!en && ists[0]));
  // R7: an unknown opcode flags error, pauses and keeps PC
  assert_bad_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_err |=> (hold_req && ists[1] && pc == $past(pc)));
  // R8: no fetch once the pause has taken effect
  assert_hold_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_req && !pend) |-> !mem_req);
  // R2: a warm reset in progress keeps the thread silent
  assert_rst_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!mem_req && !irq));
endmodule

// File: tb/tb_cmd_thread_ctrl.sv
module tb_cmd_thread_ctrl;
  localparam int SH = 0;
  localparam int BAW = 32 + SH;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, mem_valid = 1'b0, evt_go = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_req, irq;
  logic [BAW-1:0] mem_addr;
  logic [63:0] mem_rdata = '0;

  always #4 clk = ~clk;

  cmd_thread_ctrl #(.SHIFT(SH)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_valid(mem_valid), .mem_rdata(mem_rdata),
    .evt_go(evt_go), .irq(irq));

  int checks = 0, errors = 0, fetch_cnt = 0, lat_cnt = 0, cycles = 0;
  bit strict = 1'b1;
  logic [63:0] mem [0:127];
  logic [31:0] exp_q [$];
  logic [BAW-1:0] req_addr;

  function automatic logic [63:0] i_cmd();  return {8'h80, 56'h0}; endfunction
  function automatic logic [63:0] i_wait(); return {8'h20, 56'h0}; endfunction
  function automatic logic [63:0] i_bad();  return {32'h1000_0000, 32'h0}; endfunction
  function automatic logic [63:0] i_jmp(logic [31:0] t); return {32'h1000_0001, t >> SH}; endfunction
  function automatic logic [31:0] pcv(logic [31:0] b); return b >> SH; endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model plus fetch scoreboard monitor
  always @(negedge clk) begin
    #2;
    mem_valid = 1'b0;
    if (lat_cnt > 0) begin
      lat_cnt--;
      if (lat_cnt == 0) begin
        mem_valid = 1'b1;
        mem_rdata = mem[req_addr[9:3]];
      end
    end
    if (mem_req) begin
      lat_cnt = 2;
      req_addr = mem_addr;
      fetch_cnt++;
      if (exp_q.size() > 0) chk("R3/R9 fetch address", 32'(mem_addr), exp_q.pop_front());
      else if (strict) chk("R3 unexpected fetch", 32'(mem_addr), 32'hFFFF_FFFF);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic poll(logic [7:0] a, logic [31:0] m, logic [31:0] v, string tag);
    logic [31:0] d;
    for (int i = 0; i < 200; i++) begin
      rd(a, d);
      if ((d & m) == v) return;
    end
    chk(tag, d & m, v);
  endtask

  task automatic drain(string tag);
    for (int i = 0; i < 200 && exp_q.size() > 0; i++) @(negedge clk);
    chk(tag, 32'(exp_q.size()), 32'd0);
  endtask

  task automatic start(logic [31:0] pc_b, logic [31:0] end_b);
    wr(8'h24, pcv(end_b)); wr(8'h20, pcv(pc_b)); wr(8'h04, 32'd1);
  endtask

  initial begin
    logic [31:0] d, pc0;
    int fc;
    for (int i = 0; i < 128; i++) mem[i] = i_cmd();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(8'h04, d); chk("R1 run bit", d, 0);
    rd(8'h20, d); chk("R1 pc", d, 0);
    rd(8'h0C, d); chk("R1 status", d, 0);
    rd(8'h10, d); chk("R1 irq status", d, 0);
    chk("R1 irq pin", 32'(irq), 0);
    chk("R1 fetch count", 32'(fetch_cnt), 0);

    // R3 R4 linear program, R10 irq flag handling
    wr(8'h14, 32'h13);
    for (int k = 0; k < 4; k++) exp_q.push_back(32'(k * 8));
    start(32'h0, 32'h20);
    poll(8'h04, 32'h1, 32'h0, "R4 run bit clears");
    drain("R3 all fetches seen");
    rd(8'h20, d); chk("R3 pc at end", d, pcv(32'h20));
    rd(8'h10, d); chk("R4 done flag", d, 32'h1);
    chk("R10 irq raised", 32'(irq), 1);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d); chk("R10 write one keeps", d, 32'h1);
    wr(8'h10, 32'h0);
    rd(8'h10, d); chk("R10 write zero clears", d, 32'h0);
    chk("R10 irq dropped", 32'(irq), 0);

    // R5 jump with irq masked
    wr(8'h14, 32'h0);
    mem[8] = i_cmd(); mem[9] = i_jmp(32'h100); mem[32] = i_cmd();
    exp_q.push_back(32'h40); exp_q.push_back(32'h48); exp_q.push_back(32'h100);
    start(32'h40, 32'h108);
    poll(8'h04, 32'h1, 32'h0, "R4 run bit clears after jump");
    drain("R5 jump fetches");
    rd(8'h20, d); chk("R5 pc after jump", d, pcv(32'h108));
    chk("R10 masked irq", 32'(irq), 0);
    wr(8'h14, 32'h13);
    chk("R10 enable exposes flag", 32'(irq), 1);
    wr(8'h10, 32'h0);

    // R7 unknown opcode
    mem[47] = i_cmd(); mem[48] = i_bad();
    exp_q.push_back(32'h178); exp_q.push_back(32'h180);
    start(32'h178, 32'h1A0);
    poll(8'h10, 32'h2, 32'h2, "R7 error flag");
    drain("R7 fetches");
    rd(8'h08, d); chk("R7 pause request set", d, 1);
    rd(8'h0C, d); chk("R7 paused status", d, 32'h2);
    rd(8'h20, d); chk("R7 pc held", d, pcv(32'h180));
    chk("R7 irq", 32'(irq), 1);

    // R11 priority, R2 warm reset
    wr(8'h40, 32'h5);
    rd(8'h40, d); chk("R11 priority", d, 32'h5);
    wr(8'h00, 32'h1);
    rd(8'h00, d); chk("R2 reset bit reads one", d, 1);
    wr(8'h40, 32'h7);
    poll(8'h00, 32'h1, 32'h0, "R2 reset self clears");
    rd(8'h40, d); chk("R2 priority zero, busy write ignored", d, 0);
    rd(8'h20, d); chk("R2 pc zero", d, 0);
    rd(8'h24, d); chk("R2 end zero", d, 0);
    rd(8'h08, d); chk("R2 pause zero", d, 0);
    rd(8'h10, d); chk("R2 irq status zero", d, 0);
    rd(8'h14, d); chk("R2 irq enable zero", d, 0);
    rd(8'h04, d); chk("R2 run zero", d, 0);

    // R6 wait for event
    mem[4] = i_wait(); mem[5] = i_cmd();
    exp_q.push_back(32'h20);
    start(32'h20, 32'h30);
    repeat (10) @(negedge clk);
    rd(8'h30, d); chk("R6 waiting bit", d, 32'h8000_0000);
    rd(8'h20, d); chk("R6 pc parked", d, pcv(32'h20));
    chk("R6 no fetch while waiting", 32'(exp_q.size()), 0);
    exp_q.push_back(32'h28);
    @(negedge clk); evt_go = 1'b1; @(negedge clk); evt_go = 1'b0;
    poll(8'h04, 32'h1, 32'h0, "R6 completes after event");
    drain("R6 fetch after event");
    rd(8'h30, d); chk("R6 waiting bit cleared", d, 0);
    wr(8'h10, 32'h0);

    // R8 pause inside an endless loop, R9 rewrite of PC
    strict = 1'b0;
    mem[8] = i_cmd(); mem[9] = i_jmp(32'h40);
    start(32'h40, 32'h400);
    repeat (30) @(negedge clk);
    wr(8'h08, 32'h1);
    poll(8'h0C, 32'h2, 32'h2, "R8 paused status");
    fc = fetch_cnt;
    rd(8'h20, pc0);
    repeat (20) @(negedge clk);
    chk("R8 no fetch while paused", 32'(fetch_cnt), 32'(fc));
    rd(8'h20, d); chk("R8 pc stable while paused", d, pc0);
    wr(8'h20, pc0);
    exp_q.push_back(pc0 << SH);
    wr(8'h08, 32'h0);
    drain("R9 refetch from rewritten pc");
    wr(8'h00, 32'h1);
    poll(8'h00, 32'h1, 32'h0, "R2 reset during run clears");
    rd(8'h04, d); chk("R2 run cleared", d, 0);
    fc = fetch_cnt;
    repeat (20) @(negedge clk);
    chk("R2 quiet after reset", 32'(fetch_cnt), 32'(fc));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule